// File: doc/BRIEF.md
# Serial Interrupt Bus Host Controller

This block is the host end of a single-wire serialized interrupt bus. The wire is shared and open-drain: every agent can only pull it low, and a pull-up holds it high otherwise. A bus cycle has four parts. The host first pulls the wire low for a fixed Start width. The wire then carries 32 data frames of three clocks each, and the host reads the wire once in each frame without driving it. The host then pulls the wire low again for a Stop frame, whose width of two or three clocks tells every peripheral the mode of the next cycle. Last comes one released turnaround clock.

The sampled levels of the first 21 frames are collected and published as a request vector when the Stop frame begins. The remaining frames are read and discarded. After reset the controller runs one cycle on its own to collect default request levels. Later cycles start on a start request. In Quiet mode they can also start when a peripheral pulls the idle wire low for one clock. In Continuous mode a low on the idle wire is not taken as a start, so the bus stays idle while devices are removed, inserted or suspended.

Top module: `sirq_host`

## Requirements
- R1: While reset is asserted, line_oe is 0 and irq_vec is all zeros. Reset leaves the controller in Continuous mode.
- R2: On the first clock edge after reset is released, the controller begins a cycle with no start request, so line_oe is 1 in the cycle that follows that edge.
- R3: Each Start frame drives the line (line_oe = 1) for exactly START_CLKS consecutive clocks (default 4, legal range 4 to 8).
- R4: The data phase lasts 96 clocks, with line_oe = 0 throughout. Counting the first clock after Start as clock 1, frame n (n = 1..32) is the level of line_in during clock 3n−1. Levels at all other data clocks have no effect.
- R5: A sampled high means asserted. Bit k of irq_vec carries frame k+1, giving this mapping: bit 0 IRQ0, bit 1 IRQ1, bit 2 SMI, bits 3..15 IRQ3..IRQ15, bit 16 IOCHCK, bits 17..20 INTA..INTD. Frames 22 to 32 reach no output.
- R6: irq_vec changes only on the clock edge that enters the Stop frame. In the first Stop clock it shows the values sampled in that cycle.
- R7: The Stop frame follows the last data frame. It drives the line for 2 clocks when cfg_continuous is 0 in the last data clock, which selects Quiet mode. It drives the line for 3 clocks when cfg_continuous is 1, which selects Continuous mode. One clock with line_oe = 0 follows before the bus is idle.
- R8: In idle, a start_req high at a clock edge begins a cycle in either mode. In Continuous mode, a low on line_in does not begin a cycle.
- R9: In Quiet mode, a low on line_in for one idle clock begins a cycle. The controller then drives the line starting in the next clock, for the full START_CLKS clocks.
- R10: A start_req raised while a cycle is in progress is ignored. The bus stays idle after that cycle ends.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_continuous | input | 1 | Mode selected for the next cycle: 1 Continuous, 0 Quiet |
| start_req | input | 1 | Request to begin a bus cycle from idle |
| line_in | input | 1 | Level of the shared wire, synchronous to clk |
| line_oe | output | 1 | 1 pulls the shared wire low |
| irq_vec | output | NUM_REQ (21) | Latched request levels, bit k = frame k+1 |

## Verification
The assertions assume the following about the inputs:
- line_in is already synchronous to clk.
- line_in reads low whenever line_oe is 1, because the wire is open-drain.
- No peripheral pulls the wire low during Start or Stop.

The bench meets all three by modelling the wire as the AND of a peripheral drive and the inverse of line_oe, and by changing its inputs only at falling clock edges. Peripheral start pulses are issued only on an idle bus, and each lasts one clock. The timing checks rest on data clocks whose levels are the inverse of the sampled value: if the controller samples off its 3n−1 points, it latches wrong bits.

// File: rtl/sirq_pkg.sv
package sirq_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_START,
      ST_DATA,
      ST_STOP,
      ST_TURN
   } sirq_state_e;

   // every data frame spans this many clocks; sampling sits at one phase
   localparam int FRAME_CLKS   = 3;
   localparam int SAMPLE_PHASE = 1;

   // Stop-frame widths that encode the next cycle's mode
   localparam int STOP_QUIET   = 2;
   localparam int STOP_CONT    = 3;

   // legal Start-frame widths
   localparam int START_MIN    = 4;
   localparam int START_MAX    = 8;

endpackage

// File: rtl/sirq_frame_timer.sv
module sirq_frame_timer
   import sirq_pkg::*;
#(
   parameter int NUM_FRAMES = 32,
   parameter int FR_CLKS    = FRAME_CLKS,
   parameter int SMP_PHASE  = SAMPLE_PHASE
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          run,
   output logic                          sample_stb,
   output logic                          first_tick,
   output logic                          last_tick,
   output logic [$clog2(NUM_FRAMES)-1:0] frame_idx
);

   localparam int FW = $clog2(NUM_FRAMES);
   localparam int PW = (FR_CLKS > 1) ? $clog2(FR_CLKS) : 1;

   if (SMP_PHASE < 0 || SMP_PHASE >= FR_CLKS) begin : g_bad_phase
      $error("sample phase must lie inside the frame");
   end
   if (NUM_FRAMES < 2) begin : g_bad_frames
      $error("at least two frames are needed");
   end

   logic [PW-1:0] phase_q;
   logic [FW-1:0] frame_q;

   logic phase_wrap;
   assign phase_wrap = (phase_q == PW'(FR_CLKS - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= '0;
         frame_q <= '0;
      end else if (!run) begin
         phase_q <= '0;
         frame_q <= '0;
      end else if (phase_wrap) begin
         phase_q <= '0;
         frame_q <= frame_q + 1'b1;
      end else begin
         phase_q <= phase_q + 1'b1;
      end
   end

   assign sample_stb = run && (phase_q == PW'(SMP_PHASE));
   assign first_tick = run && (phase_q == '0) && (frame_q == '0);
   assign last_tick  = run && phase_wrap && (frame_q == FW'(NUM_FRAMES - 1));
   assign frame_idx  = frame_q;

   // R4: the frame counter never passes the last frame while running
   a_r4_frame_in_range: assert property (@(posedge clk) disable iff (!rst_n)
      (run && last_tick) |=> (frame_q == '0));

endmodule

// File: rtl/sirq_capture.sv
module sirq_capture #(
   parameter int NUM_REQ    = 21,
   parameter int NUM_FRAMES = 32
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          sample_stb,
   input  logic [$clog2(NUM_FRAMES)-1:0] frame_idx,
   input  logic                          line_in,
   input  logic                          commit,
   output logic [NUM_REQ-1:0]            irq_vec
);

   localparam int FW = $clog2(NUM_FRAMES);

   if (NUM_REQ > NUM_FRAMES) begin : g_bad_req
      $error("more request outputs than frames");
   end

   logic [NUM_REQ-1:0] shadow_q;
   logic [NUM_REQ-1:0] vec_q;

   // one shadow flop per assigned frame; frames past NUM_REQ have none
   for (genvar k = 0; k < NUM_REQ; k++) begin : g_slot
      logic hit;
      assign hit = sample_stb && (frame_idx == FW'(k));
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)   shadow_q[k] <= 1'b0;
         else if (hit) shadow_q[k] <= line_in;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      vec_q <= '0;
      else if (commit) vec_q <= shadow_q;
   end

   assign irq_vec = vec_q;

   // R6: the published vector moves only on the edge that closes the data phase
   a_r6_vec_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(irq_vec) |-> $past(commit));

endmodule

// File: rtl/sirq_sequencer.sv
module sirq_sequencer
   import sirq_pkg::*;
#(
   parameter int START_CLKS = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start_req,
   input  logic cfg_continuous,
   input  logic line_in,
   input  logic data_done,
   input  logic first_tick,
   input  logic sample_stb,
   output logic line_oe,
   output logic data_run
);

   localparam int LONGEST = (START_CLKS > STOP_CONT) ? START_CLKS : STOP_CONT;
   localparam int CW      = $clog2(LONGEST + 1);

   sirq_state_e st_q;
   logic [CW-1:0] cnt_q;
   logic init_pending_q;
   logic mode_cont_q;
   logic [CW-1:0] stop_last;
   logic idle_go;

   assign stop_last = mode_cont_q ? CW'(STOP_CONT - 1) : CW'(STOP_QUIET - 1);
   assign idle_go   = init_pending_q || start_req || (!mode_cont_q && !line_in);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q           <= ST_IDLE;
         cnt_q          <= '0;
         init_pending_q <= 1'b1;
         mode_cont_q    <= 1'b1;
      end else begin
         unique case (st_q)
            ST_IDLE: begin
               if (idle_go) begin
                  st_q           <= ST_START;
                  cnt_q          <= '0;
                  init_pending_q <= 1'b0;
               end
            end
            ST_START: begin
               if (cnt_q == CW'(START_CLKS - 1)) begin
                  st_q  <= ST_DATA;
                  cnt_q <= '0;
               end else begin
                  cnt_q <= cnt_q + 1'b1;
               end
            end
            ST_DATA: begin
               if (data_done) begin
                  st_q        <= ST_STOP;
                  cnt_q       <= '0;
                  mode_cont_q <= cfg_continuous;
               end
            end
            ST_STOP: begin
               if (cnt_q == stop_last) st_q <= ST_TURN;
               else                    cnt_q <= cnt_q + 1'b1;
            end
            ST_TURN: st_q <= ST_IDLE;
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   assign line_oe  = (st_q == ST_START) || (st_q == ST_STOP);
   assign data_run = (st_q == ST_DATA);

   // length of the most recent run of drive clocks, kept for the checks below
   logic [CW-1:0] oe_run_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       oe_run_q <= '0;
      else if (line_oe) oe_run_q <= oe_run_q + 1'b1;
      else              oe_run_q <= '0;
   end

   // R4: the host never drives the wire when a frame is sampled
   a_r4_release_at_sample: assert property (@(posedge clk) disable iff (!rst_n)
      sample_stb |-> !line_oe);

   // R3: the data phase opens right after a Start of exactly START_CLKS clocks
   a_r3_start_width: assert property (@(posedge clk) disable iff (!rst_n)
      first_tick |-> (oe_run_q == CW'(START_CLKS)));

   // R7: the Stop width matches the mode it announces
   a_r7_stop_width: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_TURN) |->
         (oe_run_q == (mode_cont_q ? CW'(STOP_CONT) : CW'(STOP_QUIET))));

   // R8: a low wire in Continuous idle does not begin a cycle
   a_r8_cont_ignores_wire: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_IDLE && mode_cont_q && !init_pending_q && !start_req) |=> !line_oe);

endmodule

// File: rtl/sirq_host.sv
module sirq_host
   import sirq_pkg::*;
#(
   parameter int START_CLKS = 4,
   parameter int NUM_FRAMES = 32,
   parameter int NUM_REQ    = 21
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cfg_continuous,
   input  logic               start_req,
   input  logic               line_in,
   output logic               line_oe,
   output logic [NUM_REQ-1:0] irq_vec
);

   localparam int FW = $clog2(NUM_FRAMES);

   if (START_CLKS < START_MIN || START_CLKS > START_MAX) begin : g_bad_start
      $error("START_CLKS outside the legal range");
   end
   if (NUM_REQ < 1 || NUM_REQ > NUM_FRAMES) begin : g_bad_req
      $error("NUM_REQ must be between 1 and NUM_FRAMES");
   end

   logic          data_run;
   logic          sample_stb;
   logic          first_tick;
   logic          last_tick;
   logic [FW-1:0] frame_idx;

   sirq_sequencer #(
      .START_CLKS (START_CLKS)
   ) i_seq (
      .clk            (clk),
      .rst_n          (rst_n),
      .start_req      (start_req),
      .cfg_continuous (cfg_continuous),
      .line_in        (line_in),
      .data_done      (last_tick),
      .first_tick     (first_tick),
      .sample_stb     (sample_stb),
      .line_oe        (line_oe),
      .data_run       (data_run)
   );

   sirq_frame_timer #(
      .NUM_FRAMES (NUM_FRAMES)
   ) i_timer (
      .clk        (clk),
      .rst_n      (rst_n),
      .run        (data_run),
      .sample_stb (sample_stb),
      .first_tick (first_tick),
      .last_tick  (last_tick),
      .frame_idx  (frame_idx)
   );

   sirq_capture #(
      .NUM_REQ    (NUM_REQ),
      .NUM_FRAMES (NUM_FRAMES)
   ) i_cap (
      .clk        (clk),
      .rst_n      (rst_n),
      .sample_stb (sample_stb),
      .frame_idx  (frame_idx),
      .line_in    (line_in),
      .commit     (last_tick),
      .irq_vec    (irq_vec)
   );

endmodule

// File: tb/test_sirq_host.sv
`timescale 1ns/1ps
module test_sirq_host;

   localparam int START_CLKS = 4;
   localparam int NREQ       = 21;
   localparam int NVEC       = 4;

   localparam logic [31:0] PATS [NVEC] = '{
      32'hFFE0_0000, 32'h000A_AAAA, 32'h7FF5_5555, 32'h0010_0001 };
   localparam logic [NVEC-1:0] CONTS = 4'b1010;

   logic clk = 1'b0;
   logic rst_n;
   logic cfg_continuous;
   logic start_req;
   logic periph;
   logic line_in;
   logic line_oe;
   logic [NREQ-1:0] irq_vec;

   int checks = 0;
   int fails  = 0;
   logic [NREQ-1:0] exp_vec;

   always #4 clk = ~clk;

   // open-drain wire: low if either side pulls
   assign line_in = periph & ~line_oe;

   sirq_host #(.START_CLKS(START_CLKS)) i_sirq_host (
      .clk            (clk),
      .rst_n          (rst_n),
      .cfg_continuous (cfg_continuous),
      .start_req      (start_req),
      .line_in        (line_in),
      .line_oe        (line_oe),
      .irq_vec        (irq_vec)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // called at the falling edge of the first Start clock
   task automatic run_cycle(input logic [31:0] pat, input logic cont, input bit poke);
      int n;
      cfg_continuous = cont;
      n = 0;
      while (line_oe === 1'b1 && n < 20) begin n++; @(negedge clk); end
      chk("R3 start width", n, START_CLKS);
      for (int t = 1; t <= 96; t++) begin
         int fr;
         fr = (t - 1) / 3;
         periph    = (t % 3 == 2) ? pat[fr] : ~pat[fr];
         start_req = (poke && t == 10);
         chk("R4 no drive in data", {31'd0, line_oe}, 32'd0);
         chk("R6 vector held", {11'd0, irq_vec}, {11'd0, exp_vec});
         @(negedge clk);
      end
      periph    = 1'b1;
      start_req = 1'b0;
      exp_vec   = pat[NREQ-1:0];
      chk("R5 frame mapping", {11'd0, irq_vec}, {11'd0, exp_vec});
      chk("R6 update at stop", {31'd0, line_oe}, 32'd1);
      n = 0;
      while (line_oe === 1'b1 && n < 10) begin n++; @(negedge clk); end
      chk("R7 stop width", n, cont ? 32'd3 : 32'd2);
      @(negedge clk);
      chk("R7 turnaround released", {31'd0, line_oe}, 32'd0);
   endtask

   task automatic trigger_req();
      start_req = 1'b1;
      @(negedge clk);
      start_req = 1'b0;
      chk("R8 start_req begins cycle", {31'd0, line_oe}, 32'd1);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      fails++;
      checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      rst_n = 1'b0;
      periph = 1'b1;
      cfg_continuous = 1'b1;
      start_req = 1'b0;
      exp_vec = '0;
      repeat (3) @(negedge clk);
      chk("R1 reset oe", {31'd0, line_oe}, 32'd0);
      chk("R1 reset vec", {11'd0, irq_vec}, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R2 initial cycle", {31'd0, line_oe}, 32'd1);
      run_cycle(32'h001F_FFFF, 1'b1, 1'b0);

      // vector table, every cycle started by request
      for (int v = 0; v < NVEC; v++) begin
         trigger_req();
         run_cycle(PATS[v], CONTS[v], 1'b0);
      end

      // R8: Continuous idle ignores a low wire
      periph = 1'b0;
      @(negedge clk);
      periph = 1'b1;
      for (int i = 0; i < 4; i++) begin
         chk("R8 wire ignored in continuous", {31'd0, line_oe}, 32'd0);
         @(negedge clk);
      end

      // R10: request during a cycle, which then selects Quiet mode
      trigger_req();
      run_cycle(32'h0001_2345, 1'b0, 1'b1);
      for (int i = 0; i < 4; i++) begin
         chk("R10 request in cycle ignored", {31'd0, line_oe}, 32'd0);
         @(negedge clk);
      end

      // R9: peripheral start in Quiet mode
      periph = 1'b0;
      @(negedge clk);
      periph = 1'b1;
      chk("R9 peripheral start", {31'd0, line_oe}, 32'd1);
      run_cycle(32'hABC1_8421, 1'b1, 1'b0);

      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

endmodule